// File: doc/BRIEF.md
# Global Interrupt Collector with Request Pin

This block gathers eight event sources of a peripheral-expander chip into one interrupt request line towards a host processor. Seven of the sources are one-cycle event pulses from sub-blocks (touch-sensing FIFO conditions, touch detection, firmware error, current-measurement completion). Each pulse is latched into a pending bit. The eighth source, the general-purpose pin source, is not latched. It mirrors a separate per-pin pending bank that lives outside this block.

The host reaches the block through a byte-wide register bus: address, write data, write strobe, and combinational read data. An enable register picks which pending bits may raise the request. A write-only acknowledge register clears latched bits when 1 is written to them. An output-configuration register sets the polarity of the request pin and chooses between push-pull and open-drain drive. The pin is presented as a data value and a drive-enable for the pad.

Top module: `irq_collector`

## Requirements
- R1: After synchronous reset the enable, latched pending and output-configuration registers are all zero. The pin is then open-drain and active low, and `irq_oe` is 0 (line released).
- R2: A 1 on `src_pulse[k]` (k = 1..7) sets pending bit k at the next clock edge. The bit holds until it is acknowledged. Pending reads at address 0x08 with bit k in position k: 7 FIFO overflow, 6 FIFO full, 5 FIFO threshold, 4 FIFO not empty, 3 touch detect, 2 error, 1 current measurement, 0 pin source.
- R3: A write to address 0x44 clears each latched pending bit whose write-data bit is 1 and leaves the other bits unchanged. Write-data bit 0 has no effect.
- R4: When a pulse and an acknowledge hit the same bit in the same cycle, the bit ends up set.
- R5: Pending bit 0 equals the OR of all `pin_pend` bits in the same cycle, and acknowledge writes do not clear it.
- R6: The request is active exactly when (pending AND enable) is nonzero. The enable register is read and written at address 0x42 and uses the pending bit layout.
- R7: Output config at 0x41 has bit0 = drive mode (1 push-pull, 0 open-drain) and bit1 = polarity (1 active high, 0 active low). The wanted line level is the request for active high and its inverse for active low. In push-pull mode `irq_oe`=1 and `irq_o` equals that level. In open-drain mode `irq_o`=0 and `irq_oe` is 1 only when the level is 0.
- R8: Reading 0x41 returns the two stored configuration bits with bits 7..2 zero.
- R9: Writes to 0x08 change nothing. Reads of 0x44 and of any unmapped address return 0x00.
- R10: Pending bits latch whatever the enable register holds; enable only gates the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| src_pulse | input | 7 | Event pulses for pending bits 7..1 (index k sets bit k) |
| pin_pend | input | 16 | Per-pin pending bank from the pin block |
| irq_oe | output | 1 | Pad drive-enable for the request line |
| irq_o | output | 1 | Pad data value for the request line |

## Verification
The assertions assume that event pulses and acknowledge writes arrive as clean single-cycle, synchronous values. They also assume that `pin_pend` is already synchronous to `clk`, since pending bit 0 follows it without a register. The stimulus changes every input only on the falling edge and drops the strobe and pulses after one cycle. The simultaneous set-and-acknowledge case is the only stimulus that overlaps the two. The bench sweeps all four pin configurations, every enable value and a spread of pending patterns with and without the pin source, and computes the expected pad values arithmetically.

// File: rtl/irq_collector_pkg.sv
// Shared types for the interrupt collector.
// Assumes an 8-bit register bus whose width equals the number of sources.
package irq_collector_pkg;

    // Number of event sources; also the register data width.
    localparam int unsigned NSRC = 8;
    // Number of latched sources (all except the pin-source bit 0).
    localparam int unsigned NLAT = NSRC - 1;

    // Request pin configuration as held in the output-config register.
    typedef struct packed {
        logic active_high;  // register bit1: 1 = active high
        logic push_pull;    // register bit0: 1 = push-pull, 0 = open-drain
    } pin_cfg_t;

endpackage

// File: rtl/irq_latch_bank.sv
// Bank of set/clear sticky bits for the latched interrupt sources.
// Assumes set and clear are single-cycle synchronous strobes; set wins.
module irq_latch_bank #(
    parameter int unsigned WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic bit_q;
            // Sticky pending bit: set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (set_i[i])
                    bit_q <= 1'b1;
                else if (clr_i[i])
                    bit_q <= 1'b0;
            end
            assign q_o[i] = bit_q;
        end
    endgenerate

endmodule

// File: rtl/irq_ctrl_regs.sv
// Host-writable control state: source enable mask and pin configuration.
// Assumes write enables are already decoded and last one cycle.
module irq_ctrl_regs
    import irq_collector_pkg::*;
#(
    parameter int unsigned W = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_we,
    input  logic         cfg_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q,
    output pin_cfg_t     cfg_q
);

    // Source enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_we)
            en_q <= wdata;
    end

    // Pin configuration register; only the two low bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_we)
            cfg_q <= pin_cfg_t'(wdata[1:0]);
    end

endmodule

// File: rtl/irq_pin_drive.sv
// Converts the internal request into pad data and drive-enable.
// Assumes an external pull-up holds the line when released in open-drain mode.
module irq_pin_drive
    import irq_collector_pkg::*;
(
    input  logic     req_i,
    input  pin_cfg_t cfg_i,
    output logic     oe_o,
    output logic     o_o
);

    logic level;

    // Wanted line level, then drive style.
    always_comb begin
        level = cfg_i.active_high ? req_i : ~req_i;
        if (cfg_i.push_pull) begin
            oe_o = 1'b1;
            o_o  = level;
        end else begin
            oe_o = ~level;
            o_o  = 1'b0;
        end
    end

endmodule

// File: rtl/irq_collector.sv
// Global interrupt collector: latched pending bits 7..1, pin-source bit 0
// mirrored from the per-pin bank, enable gating and a configurable request pin.
// Assumes a synchronous byte bus with a one-cycle write strobe and
// synchronous event pulses; read data is combinational on the address.
module irq_collector
    import irq_collector_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 8,
    parameter int unsigned          PIN_W     = 16,
    parameter logic [ADDR_W-1:0]    ADDR_CFG  = 'h41,
    parameter logic [ADDR_W-1:0]    ADDR_EN   = 'h42,
    parameter logic [ADDR_W-1:0]    ADDR_PEND = 'h08,
    parameter logic [ADDR_W-1:0]    ADDR_ACK  = 'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    input  logic              bus_we,
    output logic [NSRC-1:0]   bus_rdata,
    input  logic [NSRC-1:1]   src_pulse,
    input  logic [PIN_W-1:0]  pin_pend,
    output logic              irq_oe,
    output logic              irq_o
);

    logic            hit_cfg, hit_en, hit_pend, hit_ack;
    logic [NLAT-1:0] ack_clr;
    logic [NLAT-1:0] pend_lat;
    logic [NSRC-1:0] en_q;
    pin_cfg_t        cfg_q;
    logic            gpio_any;
    logic [NSRC-1:0] pend_vec;
    logic            req;

    // Address decode.
    always_comb begin
        hit_cfg  = (bus_addr == ADDR_CFG);
        hit_en   = (bus_addr == ADDR_EN);
        hit_pend = (bus_addr == ADDR_PEND);
        hit_ack  = (bus_addr == ADDR_ACK);
    end

    // Acknowledge mask for the latched bits; write-data bit 0 is dropped.
    always_comb begin
        ack_clr = (bus_we && hit_ack) ? bus_wdata[NSRC-1:1] : '0;
    end

    irq_latch_bank #(.WIDTH(NLAT)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (src_pulse),
        .clr_i (ack_clr),
        .q_o   (pend_lat)
    );

    irq_ctrl_regs #(.W(NSRC)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_we  (bus_we && hit_en),
        .cfg_we (bus_we && hit_cfg),
        .wdata  (bus_wdata),
        .en_q   (en_q),
        .cfg_q  (cfg_q)
    );

    // Pending vector: bit 0 follows the per-pin bank without a register.
    always_comb begin
        gpio_any = |pin_pend;
        pend_vec = {pend_lat, gpio_any};
        req      = |(pend_vec & en_q);
    end

    irq_pin_drive u_pin (
        .req_i (req),
        .cfg_i (cfg_q),
        .oe_o  (irq_oe),
        .o_o   (irq_o)
    );

    // Read multiplexer; write-only and unmapped addresses read zero.
    always_comb begin
        bus_rdata = '0;
        if (hit_pend)
            bus_rdata = pend_vec;
        else if (hit_en)
            bus_rdata = en_q;
        else if (hit_cfg)
            bus_rdata = {{(NSRC-2){1'b0}}, cfg_q.active_high, cfg_q.push_pull};
    end

endmodule

// File: rtl/irq_collector_chk.sv
// Property checker for the interrupt collector, bound to the top module.
// Assumes single-cycle strobes and synchronous pin_pend.
module irq_collector_chk
    import irq_collector_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 8,
    parameter int unsigned       PIN_W     = 16,
    parameter logic [ADDR_W-1:0] ADDR_CFG  = 'h41,
    parameter logic [ADDR_W-1:0] ADDR_EN   = 'h42,
    parameter logic [ADDR_W-1:0] ADDR_PEND = 'h08,
    parameter logic [ADDR_W-1:0] ADDR_ACK  = 'h44
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NSRC-1:0]   bus_wdata,
    input logic              bus_we,
    input logic [NSRC-1:0]   bus_rdata,
    input logic [NSRC-1:1]   src_pulse,
    input logic [PIN_W-1:0]  pin_pend,
    input logic              irq_oe,
    input logic              irq_o,
    input logic [NLAT-1:0]   pend_lat,
    input logic [NSRC-1:0]   en_q,
    input pin_cfg_t          cfg_q
);

    logic            ack_wr;
    logic [NLAT-1:0] clr_only;

    // Acknowledge bits not overridden by a same-cycle pulse.
    always_comb begin
        ack_wr   = bus_we && (bus_addr == ADDR_ACK);
        clr_only = ack_wr ? (bus_wdata[NSRC-1:1] & ~src_pulse) : '0;
    end

    // R2 and R4: a pulse always leaves its bit set.
    assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_pulse) |=> ((pend_lat & $past(src_pulse)) == $past(src_pulse)));

    // R2: with no pulse and no acknowledge, pending bits hold.
    assert_pend_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_wr && (src_pulse == '0)) |=> $stable(pend_lat));

    // R3: acknowledged bits without a competing pulse are cleared.
    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_only) |=> ((pend_lat & $past(clr_only)) == '0));

    // R5: pin-source pending bit read back follows the per-pin bank.
    assert_pin_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_PEND) |-> (bus_rdata[0] == (|pin_pend)));

    // R6: in push-pull active-high mode the pad carries the gated request.
    assert_req_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.push_pull && cfg_q.active_high) |->
        (irq_o == (|({pend_lat, |pin_pend} & en_q))));

    // R7: open-drain mode never drives a high level.
    assert_od_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.push_pull |-> !irq_o);

    // R7: push-pull mode always drives.
    assert_pp_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.push_pull |-> irq_oe);

    // R9: write-only and unmapped addresses read as zero.
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr != ADDR_PEND) && (bus_addr != ADDR_EN) && (bus_addr != ADDR_CFG))
        |-> (bus_rdata == '0));

endmodule

bind irq_collector irq_collector_chk #(
    .ADDR_W    (ADDR_W),
    .PIN_W     (PIN_W),
    .ADDR_CFG  (ADDR_CFG),
    .ADDR_EN   (ADDR_EN),
    .ADDR_PEND (ADDR_PEND),
    .ADDR_ACK  (ADDR_ACK)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .src_pulse (src_pulse),
    .pin_pend  (pin_pend),
    .irq_oe    (irq_oe),
    .irq_o     (irq_o),
    .pend_lat  (pend_lat),
    .en_q      (en_q),
    .cfg_q     (cfg_q)
);

// File: tb/irq_collector_tb_top.sv
`timescale 1ns/1ps
module irq_collector_tb_top;

    localparam logic [7:0] A_CFG  = 8'h41;
    localparam logic [7:0] A_EN   = 8'h42;
    localparam logic [7:0] A_PEND = 8'h08;
    localparam logic [7:0] A_ACK  = 8'h44;
    localparam logic [7:0] A_IDLE = 8'hFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = A_IDLE;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic [7:1]  src_pulse = '0;
    logic [15:0] pin_pend = '0;
    logic        irq_oe, irq_o;

    // Reference model state.
    logic [7:1]  m_pend = '0;
    logic [7:0]  m_en = '0;
    logic [1:0]  m_cfg = '0;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_collector dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .src_pulse(src_pulse),
        .pin_pend(pin_pend), .irq_oe(irq_oe), .irq_o(irq_o)
    );

    function automatic logic [7:0] m_pend_vec();
        return {m_pend, |pin_pend};
    endfunction

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Expected pad values from the model, computed arithmetically.
    task automatic check_pin(string tag);
        logic req, level, e_oe, e_o;
        req   = |(m_pend_vec() & m_en);
        level = m_cfg[1] ? req : ~req;
        e_oe  = m_cfg[0] ? 1'b1 : ~level;
        e_o   = m_cfg[0] ? level : 1'b0;
        check8(tag, {6'b0, irq_oe, irq_o}, {6'b0, e_oe, e_o});
    endtask

    task automatic write_reg(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = A_IDLE; bus_wdata = 8'h00;
        if (a == A_EN)  m_en = d;
        if (a == A_CFG) m_cfg = d[1:0];
        if (a == A_ACK) m_pend = m_pend & ~d[7:1];
    endtask

    task automatic read_chk(string tag, logic [7:0] a, logic [7:0] exp);
        bus_addr = a;
        #1;
        check8(tag, bus_rdata, exp);
        bus_addr = A_IDLE;
    endtask

    task automatic pulse(logic [7:1] m);
        @(negedge clk);
        src_pulse = m;
        @(negedge clk);
        src_pulse = '0;
        m_pend = m_pend | m;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        read_chk("R1 enable", A_EN, 8'h00);
        read_chk("R1 pending", A_PEND, 8'h00);
        read_chk("R1 cfg", A_CFG, 8'h00);
        check8("R1 pin released", {7'b0, irq_oe}, 8'h00);

        // R8 / R6: register read-back
        write_reg(A_EN, 8'h5A); read_chk("R6 enable rw", A_EN, 8'h5A);
        write_reg(A_EN, 8'hA5); read_chk("R6 enable rw", A_EN, 8'hA5);
        write_reg(A_CFG, 8'hFF); read_chk("R8 cfg rb", A_CFG, 8'h03);
        write_reg(A_CFG, 8'hFE); read_chk("R8 cfg rb", A_CFG, 8'h02);
        write_reg(A_CFG, 8'h00);
        write_reg(A_EN, 8'h00);

        // R2/R3/R10: each latched bit with enable cleared
        for (int k = 1; k < 8; k++) begin
            pulse(7'(1 << (k - 1)));
            read_chk("R2 set / R10", A_PEND, m_pend_vec());
            check_pin("R10 gated off");
            write_reg(A_ACK, 8'h01);
            read_chk("R3 bit0 no effect", A_PEND, m_pend_vec());
            write_reg(A_ACK, 8'(1 << k));
            read_chk("R3 cleared", A_PEND, 8'h00);
        end

        // R3: partial acknowledge
        pulse(7'h7F);
        write_reg(A_ACK, 8'h54);
        read_chk("R3 partial", A_PEND, 8'hAA);
        write_reg(A_ACK, 8'hFF);
        read_chk("R3 all", A_PEND, 8'h00);

        // R4: same-cycle set and acknowledge
        pulse(7'h14); // bits 5 and 3
        @(negedge clk);
        src_pulse = 7'h04; bus_addr = A_ACK; bus_wdata = 8'h28; bus_we = 1'b1;
        @(negedge clk);
        src_pulse = '0; bus_we = 1'b0; bus_addr = A_IDLE; bus_wdata = 8'h00;
        m_pend = 7'h04;
        read_chk("R4 set wins", A_PEND, 8'h08);

        // R9: writes to pending ignored, write-only and unmapped read zero
        write_reg(A_EN, 8'h08);
        write_reg(A_PEND, 8'hFF);
        read_chk("R9 pend write ignored", A_PEND, 8'h08);
        check_pin("R9 pin unchanged");
        read_chk("R9 ack reads zero", A_ACK, 8'h00);
        read_chk("R9 unmapped", 8'h00, 8'h00);
        read_chk("R9 unmapped", 8'h43, 8'h00);
        read_chk("R9 unmapped", 8'h7F, 8'h00);
        write_reg(A_ACK, 8'hFF);
        write_reg(A_EN, 8'h00);

        // R5: pin source mirrors the bank and cannot be acknowledged
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            pin_pend = 16'(1 << i);
            read_chk("R5 mirror", A_PEND, 8'h01);
            write_reg(A_ACK, 8'hFF);
            read_chk("R5 not ackable", A_PEND, 8'h01);
        end
        @(negedge clk);
        pin_pend = '0;
        read_chk("R5 cleared by bank", A_PEND, 8'h00);

        // R6/R7: sweep config x pin source x pending pattern x all enables
        for (int c = 0; c < 4; c++) begin
            write_reg(A_CFG, 8'(c));
            for (int g = 0; g < 2; g++) begin
                @(negedge clk);
                pin_pend = g[0] ? 16'h0100 : 16'h0000;
                for (int p = 0; p < 128; p += 17) begin
                    write_reg(A_ACK, 8'hFF);
                    if (p != 0) pulse(7'(p));
                    read_chk("R2 pattern", A_PEND, m_pend_vec());
                    for (int e = 0; e < 256; e++) begin
                        write_reg(A_EN, 8'(e));
                        check_pin("R6 R7 pin");
                    end
                end
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule